// File: doc/BRIEF.md
# Reset Source Status Register

This block records which source caused the most recent system reset. It presents that record as a read-only status byte with one flag per cause. Each cause arrives as a strobe from the surrounding reset logic: power-on, external pin, illegal opcode, illegal address, loss of clock, low voltage and a debug-forced request. The block's own watchdog timeout is a further cause. A cycle in which any of these strobes is high is a reset event. At the next clock edge the flags load according to which kind of reset it was.

The same register address also services a small watchdog counter. Software must write 0x55 and then 0xAA to restart the count. While the watchdog is enabled, writing any other value requests a watchdog reset. Letting the count reach its terminal value also requests one. A watchdog reset request is fed back as a reset event, so the watchdog flag shows which reset came from the watchdog.

Top module: `rst_cause_stat`

## Requirements
- R1: `statOut` bit positions are: 7 power-on, 6 external pin, 5 watchdog, 4 illegal opcode, 3 illegal address, 2 loss of clock, 1 low voltage. Bit 0 always reads 0.
- R2: A cycle with `porIn` high loads `statOut` = 0x82 at the next edge, whatever else is active. It also returns the watchdog count and the unlock sequence to their starting state.
- R3: A low-voltage reset (`lvdIn` high, with `porIn` and `dbgIn` low) keeps bit 7, sets bit 1 and clears bits 6..2 at the next edge, even if other cause strobes are high.
- R4: Any other reset event loads each of bits 6..2 with whether its source was active in that cycle. Bits 7 and 1 load 0. Several sources at once set several flags.
- R5: A debug-forced reset (`dbgIn` high, `porIn` low) clears every flag at the next edge, even if the pin or low-voltage strobes are high.
- R6: A write of 0xAA that directly follows a write of 0x55 raises `wdtClr` for exactly one cycle, starting the cycle after the 0xAA write. It also restarts the watchdog count. `statOut` does not change.
- R7: A write of 0xAA produces no `wdtClr` unless the write to this address just before it was 0x55. A second 0x55 keeps the sequence armed. Any other value disarms it.
- R8: With `wdtEn` high and no reset event in that cycle, a write of any value other than 0x55 or 0xAA raises `wdtRstReq` in the next cycle. The cycle after that, `statOut` shows the watchdog flag (0x20).
- R9: With `wdtEn` low, writes of other values raise no `wdtRstReq`.
- R10: With `wdtEn` high and no servicing, `wdtRstReq` rises TERM_COUNT edges after the count restarts from zero. The following reset loads 0x20. A valid service in between prevents the request.
- R11: Writes never change `statOut`. Flags change only on reset events. A write in a cycle that is also a reset event is ignored.
- R12: `wdtRstReq` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porIn | input | 1 | Power-on reset strobe |
| pinIn | input | 1 | External pin reset strobe |
| ilopIn | input | 1 | Illegal opcode reset strobe |
| iladIn | input | 1 | Illegal address reset strobe |
| locIn | input | 1 | Loss of clock reset strobe |
| lvdIn | input | 1 | Low-voltage reset strobe |
| dbgIn | input | 1 | Debug-forced reset strobe |
| wdtEn | input | 1 | Watchdog enable |
| wrEn | input | 1 | Write strobe for the register address |
| wrData | input | 8 | Write data |
| statOut | output | 8 | Reset cause flags |
| wdtClr | output | 1 | Watchdog service pulse |
| wdtRstReq | output | 1 | Watchdog reset request |

## Verification
The bench covers the overlap cases in the load priority. It sends low voltage together with an illegal address, debug together with pin and low voltage, and a power-on with an earlier low voltage kept in bit 7. A design with the priority in the wrong order would show a stray pin or address flag, or would lose the power-on flag. For the unlock sequence, the bench sends 0xAA with no 0x55 before it, a foreign value between the two bytes, and a repeated 0x55. A naive decoder would service the watchdog on the first two of these or miss the third. The timeout is measured to the exact edge, both with and without a service in between. An off-by-one counter, or one that ignores the service, would fire a cycle early, late or not at all.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int FLAG_W = 7;
  localparam logic [7:0] UNLOCK_A = 8'h55;
  localparam logic [7:0] UNLOCK_B = 8'hAA;

  typedef struct packed {
    logic ldPor;
    logic ldDbg;
    logic ldLvd;
    logic ldOther;
  } rcsLoad_t;
endpackage

// File: rtl/rcs_ctrl.sv
module rcs_ctrl
  import rcs_pkg::*;
#(
  parameter int TERM_COUNT = 16
) (
  input  logic       clk,
  input  logic       porIn,
  input  logic       pinIn,
  input  logic       ilopIn,
  input  logic       iladIn,
  input  logic       locIn,
  input  logic       lvdIn,
  input  logic       dbgIn,
  input  logic       wdtEn,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output rcsLoad_t   ld,
  output logic       wdtClr,
  output logic       wdtRstReq
);
  localparam int CNT_W = (TERM_COUNT > 2) ? $clog2(TERM_COUNT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM_COUNT - 1);

  logic [CNT_W-1:0] cnt;
  logic armed;
  logic anyEvt, wrOk, isA, isB, clrNext, badWr, timeout;

  always_comb begin
    anyEvt = porIn | pinIn | ilopIn | iladIn | locIn | lvdIn | dbgIn | wdtRstReq;
    ld.ldPor   = porIn;
    ld.ldDbg   = !porIn && dbgIn;
    ld.ldLvd   = !porIn && !dbgIn && lvdIn;
    ld.ldOther = anyEvt && !porIn && !dbgIn && !lvdIn;
    wrOk    = wrEn && !anyEvt;
    isA     = (wrData == UNLOCK_A);
    isB     = (wrData == UNLOCK_B);
    clrNext = wrOk && isB && armed;
    badWr   = wrOk && !isA && !isB && wdtEn;
    timeout = wdtEn && (cnt == LAST) && !anyEvt && !clrNext;
  end

  // unlock sequencer: armed means the last accepted write was 0x55
  always_ff @(posedge clk) begin
    if (anyEvt) armed <= 1'b0;
    else if (wrOk) armed <= isA;
  end

  // watchdog counter and output strobes
  always_ff @(posedge clk) begin
    wdtClr    <= clrNext;
    wdtRstReq <= badWr | timeout;
    if (anyEvt || !wdtEn || clrNext) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rcs_dpath.sv
module rcs_dpath
  import rcs_pkg::*;
(
  input  logic       clk,
  input  rcsLoad_t   ld,
  input  logic       pinIn,
  input  logic       wdtSrc,
  input  logic       ilopIn,
  input  logic       iladIn,
  input  logic       locIn,
  output logic [7:0] statOut
);
  // flags[6] = power-on ... flags[0] = low voltage
  logic [FLAG_W-1:0] flags;

  always_ff @(posedge clk) begin
    if (ld.ldPor)        flags <= 7'b1000001;
    else if (ld.ldDbg)   flags <= '0;
    else if (ld.ldLvd)   flags <= {flags[6], 6'b000001};
    else if (ld.ldOther) flags <= {1'b0, pinIn, wdtSrc, ilopIn, iladIn, locIn, 1'b0};
  end

  assign statOut = {flags, 1'b0};
endmodule

// File: rtl/rst_cause_stat.sv
module rst_cause_stat
  import rcs_pkg::*;
#(
  parameter int TERM_COUNT = 16
) (
  input  logic       clk,
  input  logic       porIn,
  input  logic       pinIn,
  input  logic       ilopIn,
  input  logic       iladIn,
  input  logic       locIn,
  input  logic       lvdIn,
  input  logic       dbgIn,
  input  logic       wdtEn,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] statOut,
  output logic       wdtClr,
  output logic       wdtRstReq
);
  rcsLoad_t ld;

  rcs_ctrl #(.TERM_COUNT(TERM_COUNT)) ctrl_i (
    .clk(clk), .porIn(porIn), .pinIn(pinIn), .ilopIn(ilopIn), .iladIn(iladIn),
    .locIn(locIn), .lvdIn(lvdIn), .dbgIn(dbgIn), .wdtEn(wdtEn), .wrEn(wrEn),
    .wrData(wrData), .ld(ld), .wdtClr(wdtClr), .wdtRstReq(wdtRstReq)
  );

  rcs_dpath dpath_i (
    .clk(clk), .ld(ld), .pinIn(pinIn), .wdtSrc(wdtRstReq), .ilopIn(ilopIn),
    .iladIn(iladIn), .locIn(locIn), .statOut(statOut)
  );
endmodule

// File: rtl/rcs_chk.sv
module rcs_chk (
  input logic       clk,
  input logic       porIn,
  input logic       pinIn,
  input logic       ilopIn,
  input logic       iladIn,
  input logic       locIn,
  input logic       lvdIn,
  input logic       dbgIn,
  input logic       wdtEn,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] statOut,
  input logic       wdtClr,
  input logic       wdtRstReq
);
  logic seen1 = 1'b0;
  logic seen2 = 1'b0;
  logic evt;

  always_ff @(posedge clk) begin
    seen1 <= seen1 | porIn;
    seen2 <= seen1;
  end

  assign evt = porIn | pinIn | ilopIn | iladIn | locIn | lvdIn | dbgIn | wdtRstReq;

  assert_bit0_zero_R1: assert property (@(posedge clk) disable iff (!seen2)
    statOut[0] == 1'b0);

  assert_por_load_R2: assert property (@(posedge clk) disable iff (!seen2)
    porIn |=> statOut == 8'h82);

  assert_lvd_load_R3: assert property (@(posedge clk) disable iff (!seen2)
    (lvdIn && !porIn && !dbgIn) |=> statOut == {$past(statOut[7]), 7'b0000010});

  assert_dbg_clear_R5: assert property (@(posedge clk) disable iff (!seen2)
    (dbgIn && !porIn) |=> statOut == 8'h00);

  assert_clr_keeps_flags_R6: assert property (@(posedge clk) disable iff (!seen2)
    wdtClr |-> $stable(statOut));

  assert_clr_after_b_R7: assert property (@(posedge clk) disable iff (!seen2)
    wdtClr |-> $past(wrEn && wrData == 8'hAA));

  assert_bad_write_R8: assert property (@(posedge clk) disable iff (!seen2)
    (wrEn && wdtEn && wrData != 8'h55 && wrData != 8'hAA && !evt) |=> wdtRstReq);

  assert_wdt_flag_R10: assert property (@(posedge clk) disable iff (!seen2)
    (wdtRstReq && !porIn && !dbgIn && !lvdIn) |=> statOut[5]);

  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!seen2)
    !evt |=> $stable(statOut));

  assert_req_pulse_R12: assert property (@(posedge clk) disable iff (!seen2)
    wdtRstReq |=> !wdtRstReq);
endmodule

bind rst_cause_stat rcs_chk chk_i (.*);

// File: tb/rst_cause_stat_tb_top.sv
module rst_cause_stat_tb_top;
  localparam int TERM = 16;
  localparam logic [6:0] C_NONE = 7'b0000000;
  localparam logic [6:0] C_POR  = 7'b1000000;
  localparam logic [6:0] C_PIN  = 7'b0100000;
  localparam logic [6:0] C_ILOP = 7'b0010000;
  localparam logic [6:0] C_ILAD = 7'b0001000;
  localparam logic [6:0] C_LOC  = 7'b0000100;
  localparam logic [6:0] C_LVD  = 7'b0000010;
  localparam logic [6:0] C_DBG  = 7'b0000001;

  logic clk = 1'b0;
  logic porIn, pinIn, ilopIn, iladIn, locIn, lvdIn, dbgIn, wdtEn, wrEn;
  logic [7:0] wrData, statOut;
  logic wdtClr, wdtRstReq;

  typedef struct {
    int         cyc;
    logic [9:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int cycNum = 0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycNum <= cycNum + 1;

  rst_cause_stat #(.TERM_COUNT(TERM)) dut_i (
    .clk(clk), .porIn(porIn), .pinIn(pinIn), .ilopIn(ilopIn), .iladIn(iladIn),
    .locIn(locIn), .lvdIn(lvdIn), .dbgIn(dbgIn), .wdtEn(wdtEn), .wrEn(wrEn),
    .wrData(wrData), .statOut(statOut), .wdtClr(wdtClr), .wdtRstReq(wdtRstReq)
  );

  function automatic logic [9:0] ex(input logic [7:0] s, input logic c, input logic r);
    return {s, c, r};
  endfunction

  // driver: one call per cycle, expectation due after the next edge
  task automatic step(input logic [6:0] cv, input logic en, input logic wr,
                      input logic [7:0] d, input logic [9:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    {porIn, pinIn, ilopIn, iladIn, locIn, lvdIn, dbgIn} = cv;
    wdtEn = en;
    wrEn = wr;
    wrData = d;
    it.cyc = cycNum + 1;
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc == cycNum) begin
      item_t it;
      it = q.pop_front();
      nChecks++;
      if ({statOut, wdtClr, wdtRstReq} !== it.exp) begin
        nFails++;
        $display("FAIL %s: stat/clr/req actual %h/%b/%b expected %h/%b/%b", it.tag,
                 statOut, wdtClr, wdtRstReq, it.exp[9:2], it.exp[1], it.exp[0]);
      end
    end
  end

  initial begin
    {porIn, pinIn, ilopIn, iladIn, locIn, lvdIn, dbgIn} = C_POR;
    wdtEn = 0; wrEn = 0; wrData = 0;
    step(C_POR, 0, 0, 8'h00, ex(8'h82, 0, 0), "R2 R1 power-on load");
    step(C_NONE, 0, 0, 8'h00, ex(8'h82, 0, 0), "R11 idle hold");
    step(C_NONE, 0, 1, 8'h12, ex(8'h82, 0, 0), "R9 bad write wdt off");
    step(C_NONE, 0, 0, 8'h00, ex(8'h82, 0, 0), "R9 R11 no request");
    step(C_PIN, 0, 0, 8'h00, ex(8'h40, 0, 0), "R4 pin reset");
    step(C_ILOP | C_LOC, 0, 0, 8'h00, ex(8'h14, 0, 0), "R4 opcode+clock");
    step(C_LVD, 0, 0, 8'h00, ex(8'h02, 0, 0), "R3 lvd after other");
    step(C_POR, 0, 0, 8'h00, ex(8'h82, 0, 0), "R2 power-on again");
    step(C_LVD, 0, 0, 8'h00, ex(8'h82, 0, 0), "R3 lvd keeps por");
    step(C_LVD | C_ILAD, 0, 0, 8'h00, ex(8'h82, 0, 0), "R3 lvd over address");
    step(C_DBG, 0, 0, 8'h00, ex(8'h00, 0, 0), "R5 debug clears");
    step(C_PIN, 0, 0, 8'h00, ex(8'h40, 0, 0), "R4 pin again");
    step(C_DBG | C_PIN | C_LVD, 0, 0, 8'h00, ex(8'h00, 0, 0), "R5 debug priority");
    step(C_PIN | C_ILAD, 0, 0, 8'h00, ex(8'h48, 0, 0), "R4 pin+address");
    // unlock sequence
    step(C_NONE, 0, 1, 8'h55, ex(8'h48, 0, 0), "R6 first byte");
    step(C_NONE, 0, 1, 8'hAA, ex(8'h48, 1, 0), "R6 service pulse");
    step(C_NONE, 0, 0, 8'h00, ex(8'h48, 0, 0), "R6 single pulse");
    step(C_NONE, 0, 1, 8'hAA, ex(8'h48, 0, 0), "R7 lone second byte");
    step(C_NONE, 0, 1, 8'h55, ex(8'h48, 0, 0), "R7 arm");
    step(C_NONE, 0, 1, 8'h12, ex(8'h48, 0, 0), "R7 R9 disarm");
    step(C_NONE, 0, 1, 8'hAA, ex(8'h48, 0, 0), "R7 no service");
    step(C_NONE, 0, 1, 8'h55, ex(8'h48, 0, 0), "R7 arm twice a");
    step(C_NONE, 0, 1, 8'h55, ex(8'h48, 0, 0), "R7 arm twice b");
    step(C_NONE, 0, 1, 8'hAA, ex(8'h48, 1, 0), "R7 repeated first byte");
    // bad write with watchdog enabled
    step(C_NONE, 1, 1, 8'h00, ex(8'h48, 0, 1), "R8 bad write request");
    step(C_NONE, 1, 0, 8'h00, ex(8'h20, 0, 0), "R8 R12 watchdog flag");
    step(C_PIN, 1, 1, 8'h00, ex(8'h40, 0, 0), "R11 write during reset ignored");
    step(C_NONE, 1, 0, 8'h00, ex(8'h40, 0, 0), "R11 no request after");
    // timeout: count restarted at the previous event edge, one edge already passed
    for (int i = 0; i < TERM - 2; i++)
      step(C_NONE, 1, 0, 8'h00, ex(8'h40, 0, 0), "R10 counting");
    step(C_NONE, 1, 0, 8'h00, ex(8'h40, 0, 1), "R10 timeout request");
    step(C_NONE, 1, 0, 8'h00, ex(8'h20, 0, 0), "R10 R12 watchdog flag");
    // service prevents timeout
    step(C_PIN, 1, 0, 8'h00, ex(8'h40, 0, 0), "R4 pin restart");
    for (int i = 0; i < 10; i++)
      step(C_NONE, 1, 0, 8'h00, ex(8'h40, 0, 0), "R10 partial count");
    step(C_NONE, 1, 1, 8'h55, ex(8'h40, 0, 0), "R6 arm");
    step(C_NONE, 1, 1, 8'hAA, ex(8'h40, 1, 0), "R6 service in time");
    for (int i = 0; i < TERM - 1; i++)
      step(C_NONE, 1, 0, 8'h00, ex(8'h40, 0, 0), "R10 serviced no request");
    step(C_NONE, 0, 0, 8'h00, ex(8'h40, 0, 0), "R10 disabled");
    step(C_NONE, 0, 0, 8'h00, ex(8'h40, 0, 0), "R9 quiet");
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule